// File: doc/BRIEF.md
# Network controller command and control register

This block is the host-facing command register of a network controller. It is one 8-bit word. The word holds the controller's run/stop condition, a transmit request flag that the hardware clears, a 3-bit remote DMA command and a 2-bit register bank select. The host writes the word through a simple write strobe. The current contents are always available on a read-data bus.

The block sequences the software stop. When the host sets the stop bit while the transmit or receive engine reports busy, the block does not go offline at once. It waits until both engines are idle and then raises a reset-complete flag. The block also applies the overlap rules for commands:

- A transmit request is ignored while the controller is not running.
- Writing 0 to the transmit bit has no effect.
- The DMA field cannot move directly between remote read and remote write.
- The DMA field does not accept the forbidden code 000.

The run/stop sequencer is a state machine with three states:

- **STOPPED**: the power-up state.
- **RUNNING**.
- **DRAINING**: the controller has been told to stop but traffic is still in progress.

Its transitions are:

- **START**: STOPPED to RUNNING, on a write with stop=0 and start=1.
- **STOP_IDLE**: RUNNING to STOPPED, on a write with stop=1 while both engines are idle.
- **STOP_BUSY**: RUNNING to DRAINING, on a write with stop=1 while either engine is busy.
- **DRAIN_DONE**: DRAINING to STOPPED, once both engines are idle.

The transmit-request tracker has two states:

- **TX_IDLE**.
- **TX_PEND**.

Its transitions are:

- **TX_REQ**: TX_IDLE to TX_PEND, on an accepted transmit request.
- **TX_END**: TX_PEND to TX_IDLE, on `tx_done`.

Top module: `nic_cmd_ctrl`

## Requirements
- R1: After reset the word reads 0x21: page 00, DMA 100, transmit 0, start 0, stop 1. `reset_done` is 1, `tx_start` is 0, `dma_cmd` is 100 and `page_sel` is 00.
- R2: A write with bit0 (stop) = 0 and bit1 (start) = 1 in STOPPED moves to RUNNING. In the next cycle the stop bit reads 0, the start bit reads 1 and `reset_done` is 0.
- R3: A write with bit0 = 1 in RUNNING while `tx_busy` and `rx_busy` are both low reaches STOPPED. In the next cycle the stop bit reads 1 and `reset_done` is 1. From the first start onward, the start bit (bit1) keeps reading 1.
- R4: A write with bit0 = 1 in RUNNING while either busy input is high sets the stop bit in the next cycle. `reset_done` stays 0 while any busy input stays high, and becomes 1 in the cycle after both are low. Writes to bits 1:0 during this wait are ignored.
- R5: A write with bit2 (transmit) = 1 and bit0 = 0 in RUNNING, while the transmit bit reads 0, sets the transmit bit. In the next cycle `tx_start` is high for exactly one cycle.
- R6: The transmit bit is cleared in the cycle after `tx_done` is high. A write with bit2 = 0 leaves the transmit bit unchanged.
- R7: A transmit request made while not RUNNING, or in the same write as bit0 = 1, is ignored. The transmit bit reads 0 and no `tx_start` pulse occurs.
- R8: Bits 5:3 are the DMA command: 001 remote read, 010 remote write, 011 send, 1xx abort. A write of 000 leaves the field unchanged. A write of 010 while the field holds 001, or of 001 while it holds 010, also leaves it unchanged. Any other code is taken in the next cycle, in any state.
- R9: Bits 7:6 select the register bank: 00 bank 0, 01 bank 1, 10 bank 2, 11 reserved. `page_sel` follows them in the cycle after every write, in any state, and holds between writes.
- R10: `rd_data` always reads {bank, DMA, transmit, start, stop}, from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| wr_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 8 | Command word written by the host |
| rd_data | output | 8 | Current command word |
| tx_busy | input | 1 | Transmit engine has a frame in progress |
| rx_busy | input | 1 | Receive engine has a frame in progress |
| tx_done | input | 1 | Transmission completed or aborted |
| tx_start | output | 1 | One-cycle pulse that launches a transmission |
| dma_cmd | output | 3 | Remote DMA command to the DMA engine |
| page_sel | output | 2 | Register bank select for the 4-bit register address |
| reset_done | output | 1 | Software reset has completed (controller stopped) |

## Verification
The assertions assume that `tx_busy`, `rx_busy` and `tx_done` are synchronous to `clk` and that `wr_en` marks one write per cycle. They place no ordering constraint between the busy inputs and the transmit flag, so a done pulse may arrive with or without a pending request. The random stimulus draws busy levels and done pulses independently of the block state. It mixes writes of every code, including the forbidden DMA code, direct read/write swaps, and start/stop combinations issued during a drain. The directed cases fix the drain length and the order of the done pulse explicitly.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;

    localparam int WORD_W = 8;
    localparam int DMA_W  = 3;
    localparam int PAGE_W = 2;

    localparam logic [DMA_W-1:0] DMA_NONE  = 3'b000;
    localparam logic [DMA_W-1:0] DMA_RD    = 3'b001;
    localparam logic [DMA_W-1:0] DMA_WR    = 3'b010;
    localparam logic [DMA_W-1:0] DMA_ABORT = 3'b100;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_RUNNING  = 2'd1,
        ST_DRAINING = 2'd2
    } run_state_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_PEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [DMA_W-1:0]  dma;
        logic              txp;
        logic              sta;
        logic              stp;
    } cmd_word_t;

endpackage

// File: rtl/nic_run_fsm.sv
module nic_run_fsm
    import nic_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_stp,
    input  logic       wr_sta,
    input  logic       traffic_busy,
    output run_state_e state,
    output logic       sta_seen,
    output logic       reset_done
);

    run_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOPPED: begin
                if (wr_en && !wr_stp && wr_sta)
                    state_nx = ST_RUNNING;
            end
            ST_RUNNING: begin
                if (wr_en && wr_stp)
                    state_nx = traffic_busy ? ST_DRAINING : ST_STOPPED;
            end
            ST_DRAINING: begin
                if (!traffic_busy)
                    state_nx = ST_STOPPED;
            end
            default: state_nx = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_STOPPED;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sta_seen   <= 1'b0;
            reset_done <= 1'b1;
        end else begin
            if (state == ST_STOPPED && state_nx == ST_RUNNING) begin
                sta_seen   <= 1'b1;
                reset_done <= 1'b0;
            end else if (state != ST_STOPPED && state_nx == ST_STOPPED) begin
                reset_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/nic_txp_ctl.sv
module nic_txp_ctl
    import nic_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic tx_done,
    output logic txp,
    output logic tx_start
);

    tx_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (set_req) state_nx = TX_PEND;
            TX_PEND: if (tx_done) state_nx = TX_IDLE;
            default: state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= TX_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_start <= 1'b0;
        else
            tx_start <= (state == TX_IDLE) && set_req;
    end

    assign txp = (state == TX_PEND);

endmodule

// File: rtl/nic_field_regs.sv
module nic_field_regs
    import nic_cmd_pkg::*;
#(
    parameter int DW = DMA_W,
    parameter int PW = PAGE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_dma,
    input  logic [PW-1:0] wr_page,
    output logic [DW-1:0] dma_q,
    output logic [PW-1:0] page_q
);

    logic swap_rw;
    logic dma_ok;

    always_comb begin
        swap_rw = ((dma_q == DMA_RD) && (wr_dma == DMA_WR)) ||
                  ((dma_q == DMA_WR) && (wr_dma == DMA_RD));
        dma_ok  = (wr_dma != DMA_NONE) && !swap_rw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_q  <= DMA_ABORT;
            page_q <= '0;
        end else if (wr_en) begin
            page_q <= wr_page;
            if (dma_ok)
                dma_q <= wr_dma;
        end
    end

endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
    import nic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              tx_busy,
    input  logic              rx_busy,
    input  logic              tx_done,
    output logic              tx_start,
    output logic [DMA_W-1:0]  dma_cmd,
    output logic [PAGE_W-1:0] page_sel,
    output logic              reset_done
);

    cmd_word_t  wr_word;
    cmd_word_t  rd_word;
    run_state_e run_state;
    logic       sta_seen;
    logic       txp;
    logic       txp_req;

    assign wr_word = cmd_word_t'(wr_data);

    nic_run_fsm u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_stp       (wr_word.stp),
        .wr_sta       (wr_word.sta),
        .traffic_busy (tx_busy | rx_busy),
        .state        (run_state),
        .sta_seen     (sta_seen),
        .reset_done   (reset_done)
    );

    assign txp_req = wr_en && wr_word.txp && !wr_word.stp && (run_state == ST_RUNNING);

    nic_txp_ctl u_txp (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (txp_req),
        .tx_done  (tx_done),
        .txp      (txp),
        .tx_start (tx_start)
    );

    nic_field_regs #(
        .DW (DMA_W),
        .PW (PAGE_W)
    ) u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_dma  (wr_word.dma),
        .wr_page (wr_word.page),
        .dma_q   (dma_cmd),
        .page_q  (page_sel)
    );

    always_comb begin
        rd_word.page = page_sel;
        rd_word.dma  = dma_cmd;
        rd_word.txp  = txp;
        rd_word.sta  = sta_seen;
        rd_word.stp  = (run_state != ST_RUNNING);
    end

    assign rd_data = rd_word;

endmodule

// File: rtl/nic_cmd_ctrl_chk.sv
module nic_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       tx_busy,
    input logic       rx_busy,
    input logic       tx_done,
    input logic       tx_start,
    input logic [2:0] dma_cmd,
    input logic [1:0] page_sel,
    input logic       reset_done
);

    AST_DONE_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done |-> rd_data[0]); // R3

    AST_DONE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_done) |-> (!$past(tx_busy) && !$past(rx_busy))); // R4

    AST_PULSE_WITH_TXP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> rd_data[2]); // R5

    AST_TXP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2] && !tx_done) |=> rd_data[2]); // R6

    AST_NO_PULSE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !$past(rd_data[0])); // R7

    AST_DMA_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cmd != 3'b000); // R8

    AST_NO_RD_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_cmd == 3'b001) |=> (dma_cmd != 3'b010)); // R8

    AST_NO_WR_TO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_cmd == 3'b010) |=> (dma_cmd != 3'b001)); // R8

    AST_PAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(page_sel)); // R9

endmodule

bind nic_cmd_ctrl nic_cmd_ctrl_chk u_chk (.*);

// File: tb/tb_nic_cmd_ctrl.sv
module tb_nic_cmd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tx_busy = 1'b0;
    logic       rx_busy = 1'b0;
    logic       tx_done = 1'b0;
    logic       tx_start;
    logic [2:0] dma_cmd;
    logic [1:0] page_sel;
    logic       reset_done;

    nic_cmd_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // bench reference: 0 run, 1 drain, 2 stopped
    int         m_st;
    logic       m_sta, m_txp, m_done, m_pulse;
    logic [2:0] m_dma;
    logic [1:0] m_page;

    function automatic logic [7:0] exp_word();
        return {m_page, m_dma, m_txp, m_sta, (m_st != 0)};
    endfunction

    function automatic logic dma_taken(logic [2:0] cur, logic [2:0] c);
        if (c == 3'b000) return 1'b0;
        if (cur == 3'b001 && c == 3'b010) return 1'b0;
        if (cur == 3'b010 && c == 3'b001) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 2; m_sta = 0; m_txp = 0; m_done = 1; m_pulse = 0;
        m_dma = 3'b100; m_page = 2'b00;
    endtask

    task automatic compare_all(string tag);
        chk({tag, " R10 rd_data"}, 32'(rd_data), 32'(exp_word()));
        chk({tag, " R5 tx_start"}, 32'(tx_start), 32'(m_pulse));
        chk({tag, " R4 reset_done"}, 32'(reset_done), 32'(m_done));
        chk({tag, " R8 dma_cmd"}, 32'(dma_cmd), 32'(m_dma));
        chk({tag, " R9 page_sel"}, 32'(page_sel), 32'(m_page));
    endtask

    // called at a falling edge: drive, advance one clock, compare at next falling edge
    task automatic step(string tag, logic we, logic [7:0] wd, logic txb, logic rxb, logic txd);
        logic busy;
        int   nst;
        logic ntxp, ndone, nsta;
        wr_en = we; wr_data = wd; tx_busy = txb; rx_busy = rxb; tx_done = txd;
        busy = txb | rxb;
        nst = m_st; ntxp = m_txp; ndone = m_done; nsta = m_sta; m_pulse = 0;
        if (m_txp && txd) ntxp = 0;
        case (m_st)
            2: if (we && !wd[0] && wd[1]) begin nst = 0; ndone = 0; nsta = 1; end
            0: begin
                if (we && wd[0]) begin
                    nst = busy ? 1 : 2;
                    ndone = !busy;
                end else if (we && wd[2] && !m_txp) begin
                    ntxp = 1; m_pulse = 1;
                end
            end
            default: if (!busy) begin nst = 2; ndone = 1; end
        endcase
        if (we) begin
            m_page = wd[7:6];
            if (dma_taken(m_dma, wd[5:3])) m_dma = wd[5:3];
        end
        m_st = nst; m_txp = ntxp; m_done = ndone; m_sta = nsta;
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rd_data", 32'(rd_data), 32'h21);
        chk("R1 reset_done", 32'(reset_done), 32'd1);
        chk("R1 tx_start", 32'(tx_start), 32'd0);
        compare_all("R1");

        // R7 transmit request while stopped
        step("R7 stopped", 1, 8'h04, 0, 0, 0);
        chk("R7 txp ignored", 32'(rd_data[2]), 32'd0);

        // R2 start
        step("R2", 1, 8'h02, 0, 0, 0);
        chk("R2 stop bit", 32'(rd_data[0]), 32'd0);
        chk("R2 start bit", 32'(rd_data[1]), 32'd1);
        chk("R2 reset_done", 32'(reset_done), 32'd0);

        // R5 transmit request, one-cycle pulse
        step("R5", 1, 8'h06, 0, 0, 0);
        chk("R5 pulse", 32'(tx_start), 32'd1);
        step("R5 after", 0, 8'h00, 0, 0, 0);
        chk("R5 pulse ends", 32'(tx_start), 32'd0);

        // R6 write 0 has no effect, done clears
        step("R6 write0", 1, 8'h22, 0, 0, 0);
        chk("R6 txp held", 32'(rd_data[2]), 32'd1);
        step("R6 done", 0, 8'h00, 0, 0, 1);
        chk("R6 txp cleared", 32'(rd_data[2]), 32'd0);

        // R8 DMA field rules
        step("R8 rd", 1, 8'h0A, 0, 0, 0);
        step("R8 swap", 1, 8'h12, 0, 0, 0);
        chk("R8 rd->wr refused", 32'(dma_cmd), 32'd1);
        step("R8 abort", 1, 8'h22, 0, 0, 0);
        step("R8 wr", 1, 8'h12, 0, 0, 0);
        chk("R8 wr after abort", 32'(dma_cmd), 32'd2);
        step("R8 zero", 1, 8'h02, 0, 0, 0);
        chk("R8 000 refused", 32'(dma_cmd), 32'd2);

        // R9 page select
        step("R9", 1, 8'hA2, 0, 0, 0);
        chk("R9 page2", 32'(page_sel), 32'd2);

        // R4 stop while busy, drain, R7 request in same write / during drain
        step("R4 stop", 1, 8'hA7, 1, 0, 0);
        chk("R4 stop bit", 32'(rd_data[0]), 32'd1);
        chk("R4 not done", 32'(reset_done), 32'd0);
        chk("R7 same write", 32'(tx_start), 32'd0);
        step("R4 restart ignored", 1, 8'h62, 0, 1, 0);
        chk("R4 stays stopped", 32'(rd_data[0]), 32'd1);
        chk("R4 still draining", 32'(reset_done), 32'd0);
        chk("R9 page in drain", 32'(page_sel), 32'd1);
        step("R7 drain", 1, 8'h66, 1, 1, 0);
        chk("R7 no pulse drain", 32'(tx_start), 32'd0);
        step("R4 idle", 0, 8'h00, 0, 0, 0);
        chk("R4 done", 32'(reset_done), 32'd1);

        // R3 stop while idle, STA stays 1
        step("R3 start", 1, 8'h02, 0, 0, 0);
        step("R3 stop", 1, 8'h01, 0, 0, 0);
        chk("R3 done", 32'(reset_done), 32'd1);
        chk("R3 start bit", 32'(rd_data[1]), 32'd1);

        // random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            logic       we;
            logic [7:0] wd;
            we = ($urandom_range(0, 9) < 4);
            wd = 8'($urandom);
            if ($urandom_range(0, 3) == 0) wd[1:0] = 2'b10;
            step("RND", we, wd,
                 ($urandom_range(0, 4) == 0),
                 ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 3) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule